// File: doc/BRIEF.md
# Aging Victim Selector

This block chooses which frame of a fully associative store should be evicted next. Every frame carries a one-bit "used" flag that is raised by any access to the frame, and a shift register of recent usage. A periodic tick pushes each used flag into the top of its frame's usage register and then clears the flag. Over time, the register of a frame that has been busy holds a large unsigned value. The register of an idle frame decays toward zero.

On a request, the selector walks the frames one per cycle. An empty frame, meaning one whose valid flag is low, wins over every occupied frame. When no frame is empty, the winner is the occupied frame with the smallest usage value. At the end of the walk the block pulses `done` and presents the chosen index on `victim`. The index stays there until the next result.

A frame whose valid flag is low holds a cleared usage register, so a frame that has just been filled starts with no history.

Top module: `aging_victim_sel`

## Requirements
- R1: After reset, `done` is 0 and `victim` is 0. All used flags and usage registers are clear, so a request with every frame valid returns frame 0.
- R2: An access strobe (`acc_valid`=1 with `acc_frame`=i) sets frame i's used flag when frame i is valid. An access to a frame whose valid flag is low has no effect.
- R3: On each `tick`, every valid frame's usage register shifts right by one. The used flag enters at the most significant bit, the least significant bit is discarded, and the used flag is then cleared.
- R4: An access to a frame in the same cycle as a `tick` shifts in the flag value from before that cycle, and it leaves the used flag set for the following period.
- R5: While a frame's valid bit (`frame_valid[i]`) is 0, its usage register and used flag are held at zero, so a frame that becomes valid starts with a zero history.
- R6: If any frame is invalid, the result is the lowest-numbered invalid frame, whatever the usage values are.
- R7: If all frames are valid, the result is the frame with the smallest unsigned usage value. Ties go to the lowest index.
- R8: A request sampled at a clock edge produces a `done` pulse that is exactly one cycle wide, NUM_FRAMES cycles later. `victim` changes only together with `done` and holds its value between results.
- R9: A request that arrives while a walk is in progress is ignored. It produces no extra `done` pulse and does not restart the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid | input | 1 | Access strobe |
| acc_frame | input | $clog2(NUM_FRAMES) | Frame touched by the access |
| tick | input | 1 | Periodic aging strobe |
| frame_valid | input | NUM_FRAMES | Per-frame occupied flags |
| req | input | 1 | Start a victim search |
| done | output | 1 | One-cycle result strobe |
| victim | output | $clog2(NUM_FRAMES) | Chosen frame index |

## Verification
The bench builds the block with four frames and a four-bit usage register. With these sizes, a single tick moves a usage bit a quarter of the way through its register, and three ticks push older bits out of the low end. The bench walks a vector table of validity masks, access sets and tick counts, and compares each walk's result with a hand-derived index. This reaches ties, decay to zero, empty-frame priority, and refill clearing within a few dozen cycles. Directed tests then cover accesses to empty frames, an access that coincides with a tick, and a second request that arrives during a walk.

// File: rtl/aging_sel_pkg.sv
package aging_sel_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/avs_rst_sync.sv
module avs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/avs_frame_age.sv
module avs_frame_age #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              hit,
  input  logic              tick,
  output logic [HIST_W-1:0] hist
);
  logic              used_q, used_n;
  logic [HIST_W-1:0] hist_q, hist_n;

  always_comb begin
    used_n = used_q;
    hist_n = hist_q;
    if (!valid) begin
      used_n = 1'b0;
      hist_n = '0;
    end else if (tick) begin
      hist_n = {used_q, hist_q[HIST_W-1:1]};
      used_n = hit;
    end else if (hit) begin
      used_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= 1'b0;
      hist_q <= '0;
    end else begin
      used_q <= used_n;
      hist_q <= hist_n;
    end
  end

  assign hist = hist_q;

  // R2: an access to a valid frame leaves its used flag set
  p_used_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid && hit |=> used_q);

  // R3: the shifted-in top bit equals the flag held before the tick
  p_shift_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid && tick && !hit |=> (hist_q[HIST_W-1] == $past(used_q)) && !used_q);

  // R4: a coincident access survives the tick
  p_tick_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && tick && hit |=> used_q && (hist_q[HIST_W-1] == $past(used_q)));

  // R5: an empty frame carries no history
  p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (hist_q == '0) && !used_q);
endmodule

// File: rtl/avs_min_scan.sv
module avs_min_scan
  import aging_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int HIST_W     = 8,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req,
  input  logic [NUM_FRAMES-1:0]              frame_valid,
  input  logic [NUM_FRAMES-1:0][HIST_W-1:0]  hist_all,
  output logic                               done,
  output logic [IDX_W-1:0]                   victim
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  scan_state_e       state_q, state_n;
  logic [IDX_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  best_q, best_n;
  logic [HIST_W-1:0] best_h_q, best_h_n;
  logic              found_q, found_n;
  logic              have_q, have_n;
  logic              done_q, done_n;
  logic [IDX_W-1:0]  victim_q, victim_n;
  logic              cur_v;
  logic [HIST_W-1:0] cur_h;

  assign cur_v = frame_valid[cnt_q];
  assign cur_h = hist_all[cnt_q];

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    best_n   = best_q;
    best_h_n = best_h_q;
    found_n  = found_q;
    have_n   = have_q;
    done_n   = 1'b0;
    victim_n = victim_q;
    unique case (state_q)
      SCAN_IDLE: begin
        if (req) begin
          state_n = SCAN_RUN;
          cnt_n   = '0;
          found_n = 1'b0;
          have_n  = 1'b0;
        end
      end
      SCAN_RUN: begin
        if (!found_q) begin
          if (!cur_v) begin
            found_n = 1'b1;
            best_n  = cnt_q;
          end else if (!have_q || (cur_h < best_h_q)) begin
            have_n   = 1'b1;
            best_n   = cnt_q;
            best_h_n = cur_h;
          end
        end
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) begin
          state_n  = SCAN_IDLE;
          done_n   = 1'b1;
          victim_n = best_n;
        end
      end
      default: state_n = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SCAN_IDLE;
      cnt_q    <= '0;
      best_q   <= '0;
      best_h_q <= '0;
      found_q  <= 1'b0;
      have_q   <= 1'b0;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      best_q   <= best_n;
      best_h_q <= best_h_n;
      found_q  <= found_n;
      have_q   <= have_n;
      done_q   <= done_n;
      victim_q <= victim_n;
    end
  end

  assign done   = done_q;
  assign victim = victim_q;

  // R6: once an empty frame is found, the candidate no longer moves
  p_empty_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCAN_RUN) && found_q |=> best_q == $past(best_q));

  // R7: a replacement candidate never has a larger history than the one it replaces
  p_min_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCAN_RUN) && have_q && !found_q && cur_v |=> best_h_q <= $past(best_h_q));

  // R8: the result strobe lasts exactly one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: the index only moves with the strobe
  p_victim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(victim_q));

  // R9: a walk in progress continues regardless of new requests
  p_walk_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCAN_RUN) && (cnt_q != LAST_IDX) |=> (state_q == SCAN_RUN) && !done_q);
endmodule

// File: rtl/aging_victim_sel.sv
module aging_victim_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int HIST_W     = 8,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_frame,
  input  logic                  tick,
  input  logic [NUM_FRAMES-1:0] frame_valid,
  input  logic                  req,
  output logic                  done,
  output logic [IDX_W-1:0]      victim
);
  logic                              rst_int_n;
  logic [NUM_FRAMES-1:0][HIST_W-1:0] hist_all;

  avs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar gi = 0; gi < NUM_FRAMES; gi++) begin : g_frame
    logic hit;
    assign hit = acc_valid && (acc_frame == IDX_W'(gi));

    avs_frame_age #(.HIST_W(HIST_W)) u_age (
      .clk   (clk),
      .rst_n (rst_int_n),
      .valid (frame_valid[gi]),
      .hit   (hit),
      .tick  (tick),
      .hist  (hist_all[gi])
    );
  end

  avs_min_scan #(.NUM_FRAMES(NUM_FRAMES), .HIST_W(HIST_W)) u_scan (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req         (req),
    .frame_valid (frame_valid),
    .hist_all    (hist_all),
    .done        (done),
    .victim      (victim)
  );

  // R1: no result strobe while reset is held internally
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_int_n |=> !done || !$past(rst_int_n) == 1'b0);
endmodule

// File: tb/aging_victim_sel_tb.sv
`timescale 1ns/1ps
module aging_victim_sel_tb;
  localparam int N  = 4;
  localparam int W  = 4;
  localparam int IW = $clog2(N);
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid;
  logic [IW-1:0] acc_frame;
  logic          tick;
  logic [N-1:0]  frame_valid;
  logic          req;
  logic          done;
  logic [IW-1:0] victim;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  aging_victim_sel #(.NUM_FRAMES(N), .HIST_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .tick(tick), .frame_valid(frame_valid), .req(req), .done(done), .victim(victim)
  );

  // vector: {valid mask, access mask, tick count, expected victim}
  localparam logic [12:0] VEC [NV] = '{
    {4'b0000, 4'b0000, 3'd0, 2'd0},  // R6 all empty -> 0
    {4'b1111, 4'b0000, 3'd0, 2'd0},  // R7 all tie -> 0
    {4'b1111, 4'b0001, 3'd1, 2'd1},  // R3
    {4'b1111, 4'b0010, 3'd1, 2'd2},  // R3
    {4'b1111, 4'b1100, 3'd1, 2'd0},  // R7
    {4'b1111, 4'b0000, 3'd3, 2'd0},  // R3 decay, tie
    {4'b1111, 4'b0101, 3'd1, 2'd1},  // R7
    {4'b1111, 4'b1010, 3'd1, 2'd0},  // R7 tie lowest
    {4'b1011, 4'b0000, 3'd0, 2'd2},  // R6 empty wins
    {4'b1111, 4'b0000, 3'd0, 2'd2},  // R5 refill cleared
    {4'b0110, 4'b0000, 3'd0, 2'd0},  // R6 lowest empty
    {4'b1111, 4'b0110, 3'd1, 2'd0}   // R5 R7
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic touch(input int f);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_frame = IW'(f);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic request(output int got);
    int cyc;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == N, "R8 done latency", cyc, N);
    got = int'(victim);
    @(negedge clk);
    chk(!done, "R8 done width", int'(done), 0);
    chk(int'(victim) == got, "R8 victim hold", int'(victim), got);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int got;
    rst_n = 1'b0;
    acc_valid = 1'b0;
    acc_frame = '0;
    tick = 1'b0;
    frame_valid = '0;
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done, "R1 reset done", int'(done), 0);
    chk(victim == '0, "R1 reset victim", int'(victim), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    frame_valid = '1;
    request(got);
    chk(got == 0, "R1 cleared history", got, 0);

    for (int v = 0; v < NV; v++) begin
      logic [12:0] e;
      e = VEC[v];
      @(negedge clk);
      frame_valid = e[12:9];
      for (int f = 0; f < N; f++) if (e[5+f]) touch(f);
      for (int t = 0; t < int'(e[4:2]); t++) pulse_tick();
      request(got);
      chk(got == int'(e[1:0]), $sformatf("R7 R6 vector %0d", v), got, int'(e[1:0]));
    end

    // R2: access to an empty frame is ignored
    @(negedge clk);
    frame_valid = 4'b1110;
    touch(0);
    @(negedge clk);
    frame_valid = 4'b1111;
    pulse_tick();
    request(got);
    chk(got == 0, "R2 empty access ignored", got, 0);

    // R4: access in the tick cycle keeps the flag set
    touch(0);
    touch(1);
    touch(2);
    @(negedge clk);
    tick = 1'b1;
    acc_valid = 1'b1;
    acc_frame = IW'(3);
    @(negedge clk);
    tick = 1'b0;
    acc_valid = 1'b0;
    pulse_tick();
    request(got);
    chk(got == 0, "R4 coincident access", got, 0);

    // R9: a second request during a walk is ignored
    begin
      int dones;
      int first_at;
      dones = 0;
      first_at = -1;
      @(negedge clk);
      req = 1'b1;
      for (int i = 1; i <= 3 * N; i++) begin
        @(negedge clk);
        if (done) begin
          dones++;
          if (first_at < 0) first_at = i;
        end
        req = (i == 2);
      end
      req = 1'b0;
      chk(dones == 1, "R9 single done", dones, 1);
      chk(first_at == N + 1, "R9 no restart", first_at, N + 1);
      chk(victim == '0, "R9 result", int'(victim), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule